// File: doc/BRIEF.md
# Beat Normality Classifier (38-4-1 Neural Network)

This block decides whether one heartbeat is normal or abnormal. Its input is a vector of 38 signed fixed-point feature coefficients that an upstream wavelet stage produces for each beat. The samples arrive one per accepted cycle, and the last one is marked with a flag. The block evaluates a fixed fully connected network with four hidden neurons and one output neuron. Each neuron adds a bias to the weighted sum of its inputs and passes the result through a fifth-order polynomial approximation of the hyperbolic-tangent sigmoid. The block reports the decision as one bit, together with a one-cycle strobe.

A single multiply-accumulate datapath serves every neuron in turn. The block therefore holds the whole vector and accepts nothing while it computes. The weights and biases are not stored as a table. They come from closed-form integer formulas evaluated in the datapath's index counters, so a different network only needs different formula constants.

Numbers use a signed Q format with 12 fractional bits in a 16-bit word, so 1.0 is 4096.

Top module: `ecg_beat_nn`

## Requirements
- R1: After reset, `in_ready` is 1 and both `out_valid` and `out_abnormal` are 0.
- R2: A sample is taken on a rising edge where `in_valid` and `in_ready` are both 1. Samples fill positions x0, x1, ... in arrival order, and the sample carrying `in_last` closes the vector. Idle cycles between samples have no effect.
- R3: A vector closed before position 37 treats the missing positions as zero. Samples offered after 38 have been stored, and before the closing one, are discarded, including the value of the closing sample itself.
- R4: Hidden neuron j (0..3) forms a = b_j*4096 + sum of x_i*w_ji, where w_ji = (((7i + 13j + 3) mod 17) - 8)*64 and b_j = (((5j) mod 7) - 3)*256. Its argument is z = floor(a / 4096).
- R5: The activation clamps z to [-6144, 6144]. It then computes z2 = floor(z*z/4096), z3 = floor(z2*z/4096) and z5 = floor(z3*z2/4096). The result y = z - floor(z3*1365/4096) + floor(z5*546/4096) is saturated to [-4096, 4096].
- R6: The output neuron uses the four hidden activations h_j with weights 1024, -2048, 3072, -4096 (for j = 0..3) and bias 256. It applies the same R4 scaling and R5 activation. `out_abnormal` is 1 when the resulting activation is >= 0 and 0 otherwise.
- R7: `out_valid` is a single-cycle pulse. It rises exactly 161 rising edges after the edge that took the closing sample. `out_abnormal` keeps its value until the next pulse.
- R8: `in_ready` is 0 from the edge that takes the closing sample until `out_valid` rises, and 1 in that cycle. Samples offered while `in_ready` is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample on `in_data` is offered |
| in_last | input | 1 | Offered sample closes the vector |
| in_data | input | 16 | Signed Q3.12 feature sample |
| in_ready | output | 1 | Block can take a sample |
| out_valid | output | 1 | One-cycle strobe with the decision |
| out_abnormal | output | 1 | 1 = abnormal beat, 0 = normal |

## Verification
The bench sends vectors with mixed signs, with large magnitudes that drive every neuron into the clamp and the saturation, and with idle gaps between samples. It compares each decision against an integer model of the network. A design that truncated towards zero instead of flooring, skipped the clamp, or mixed up neuron order would flip some of these decisions. Short and overlong vectors check that missing positions read as zero and that surplus samples are dropped. A design that kept stale samples or wrapped the write index would classify those beats from the wrong data. Samples and closing flags driven during the busy window must not be taken, and the latency must be exactly 161 edges. A leaky ready or an off-by-one sequencer would show up as a wrong next decision or a shifted strobe.

// File: rtl/ecg_beat_nn.sv
module ecg_beat_nn #(
  parameter int N_IN  = 38,
  parameter int N_HID = 4,
  parameter int DW    = 16,
  parameter int FRAC  = 12,
  parameter int AW    = 40,
  parameter int ZMAX  = 6144
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic          out_abnormal
);
  localparam int ONE = 1 << FRAC;
  localparam int C3  = (ONE + 1) / 3;
  localparam int C5  = (2 * ONE) / 15;
  localparam int IW  = $clog2(N_IN);
  localparam int NW  = $clog2(N_IN + 1);
  localparam int JW  = (N_HID > 1) ? $clog2(N_HID) : 1;
  localparam int PW  = 2 * DW;
  localparam int LAT = N_HID * (N_IN + 1) + N_HID + 1;

  typedef enum logic [2:0] {S_IDLE, S_HMAC, S_HACT, S_OMAC, S_OACT} st_t;

  function automatic logic signed [DW-1:0] w_hid(int j, int i);
    return DW'((((i * 7 + j * 13 + 3) % 17) - 8) * (ONE / 64));
  endfunction

  function automatic logic signed [AW-1:0] b_hid(int j);
    longint v;
    v = longint'((((j * 5) % 7) - 3) * (ONE / 16));
    return AW'(v * ONE);
  endfunction

  function automatic logic signed [DW-1:0] w_out(int j);
    return DW'(((j % 2 == 1) ? -1 : 1) * (j + 1) * (ONE / 4));
  endfunction

  function automatic logic signed [DW-1:0] act_f(logic signed [AW-1:0] a);
    logic signed [AW-1:0] z;
    longint zc, z2, z3, z5, y;
    z = a >>> FRAC;
    if (z > AW'(ZMAX))       zc = longint'(ZMAX);
    else if (z < -AW'(ZMAX)) zc = -longint'(ZMAX);
    else                     zc = longint'(z);
    z2 = (zc * zc) >>> FRAC;
    z3 = (z2 * zc) >>> FRAC;
    z5 = (z3 * z2) >>> FRAC;
    y  = zc - ((z3 * C3) >>> FRAC) + ((z5 * C5) >>> FRAC);
    if (y > longint'(ONE))   y = longint'(ONE);
    if (y < -longint'(ONE))  y = -longint'(ONE);
    return DW'(y);
  endfunction

  st_t st;
  logic [IW-1:0] idx_i;
  logic [JW-1:0] idx_j;
  logic [NW-1:0] n_rcv;
  logic signed [AW-1:0] acc;
  logic signed [DW-1:0] xbuf [N_IN];
  logic signed [DW-1:0] hbuf [N_HID];
  logic signed [DW-1:0] op_x, op_w, act_y;
  logic signed [PW-1:0] prod;
  logic take;

  assign in_ready = (st == S_IDLE);
  assign take     = in_valid && in_ready;
  assign act_y    = act_f(acc);
  assign prod     = op_x * op_w;

  always_comb begin
    if (st == S_OMAC) begin
      op_x = hbuf[idx_j];
      op_w = w_out(int'(idx_j));
    end else begin
      op_x = (NW'(idx_i) < n_rcv) ? xbuf[idx_i] : '0;
      op_w = w_hid(int'(idx_j), int'(idx_i));
    end
  end

  always_ff @(posedge clk) begin
    if (take && n_rcv < NW'(N_IN)) xbuf[n_rcv[IW-1:0]] <= in_data;
    if (st == S_HACT) hbuf[idx_j] <= act_y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      idx_i        <= '0;
      idx_j        <= '0;
      n_rcv        <= '0;
      acc          <= '0;
      out_valid    <= 1'b0;
      out_abnormal <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          if (n_rcv < NW'(N_IN)) n_rcv <= n_rcv + 1'b1;
          if (in_last) begin
            st    <= S_HMAC;
            idx_i <= '0;
            idx_j <= '0;
            acc   <= b_hid(0);
          end
        end
        S_HMAC: begin
          acc <= acc + {{(AW-PW){prod[PW-1]}}, prod};
          if (idx_i == IW'(N_IN - 1)) begin
            idx_i <= '0;
            st    <= S_HACT;
          end else begin
            idx_i <= idx_i + 1'b1;
          end
        end
        S_HACT: begin
          if (idx_j == JW'(N_HID - 1)) begin
            idx_j <= '0;
            acc   <= AW'(longint'(ONE / 16) * ONE);
            st    <= S_OMAC;
          end else begin
            idx_j <= idx_j + 1'b1;
            acc   <= b_hid(int'(idx_j) + 1);
            st    <= S_HMAC;
          end
        end
        S_OMAC: begin
          acc <= acc + {{(AW-PW){prod[PW-1]}}, prod};
          if (idx_j == JW'(N_HID - 1)) st <= S_OACT;
          else idx_j <= idx_j + 1'b1;
        end
        S_OACT: begin
          out_valid    <= 1'b1;
          out_abnormal <= ~act_y[DW-1];
          n_rcv        <= '0;
          idx_j        <= '0;
          st           <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecg_beat_nn_chk.sv
module ecg_beat_nn_chk #(
  parameter int N_IN  = 38,
  parameter int N_HID = 4,
  parameter int DW    = 16,
  parameter int FRAC  = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_last,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic signed [DW-1:0] act_y
);
  localparam int LAT = N_HID * (N_IN + 1) + N_HID + 1;
  localparam int ONE = 1 << FRAC;

  logic [15:0] cnt;
  logic run;
  logic closing;

  assign closing = in_valid && in_ready && in_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (closing) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 16'd1;
      if (out_valid) run <= 1'b0;
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r7_exact_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (run && cnt == 16'(LAT)));

  a_r8_busy_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    closing |=> !in_ready);

  a_r8_ready_at_decision: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  a_r5_act_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (act_y <= DW'(ONE)) && (act_y >= -DW'(ONE)));
endmodule

bind ecg_beat_nn ecg_beat_nn_chk #(
  .N_IN(N_IN), .N_HID(N_HID), .DW(DW), .FRAC(FRAC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
  .in_ready(in_ready), .out_valid(out_valid), .act_y(act_y)
);

// File: tb/sim_ecg_beat_nn.sv
module sim_ecg_beat_nn;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_last = 1'b0;
  logic [15:0] in_data = '0;
  logic in_ready, out_valid, out_abnormal;

  int checks = 0;
  int errs = 0;
  int vec [64];
  int lfsr = 32'h1ACE5;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ecg_beat_nn u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_abnormal(out_abnormal)
  );

  function automatic longint act_m(longint a);
    longint z, z2, z3, z5, y;
    z = a >>> 12;
    if (z > 6144) z = 6144;
    if (z < -6144) z = -6144;
    z2 = (z * z) >>> 12;
    z3 = (z2 * z) >>> 12;
    z5 = (z3 * z2) >>> 12;
    y = z - ((z3 * 1365) >>> 12) + ((z5 * 546) >>> 12);
    if (y > 4096) y = 4096;
    if (y < -4096) y = -4096;
    return y;
  endfunction

  function automatic bit model_abn(int n);
    longint h [4];
    longint a;
    longint vo [4] = '{1024, -2048, 3072, -4096};
    for (int j = 0; j < 4; j++) begin
      a = longint'((((j * 5) % 7) - 3) * 256) * 4096;
      for (int i = 0; i < 38; i++)
        if (i < n) a += longint'(vec[i]) * longint'((((i * 7 + j * 13 + 3) % 17) - 8) * 64);
      h[j] = act_m(a);
    end
    a = 256 * 4096;
    for (int j = 0; j < 4; j++) a += h[j] * vo[j];
    return act_m(a) >= 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd(int amp);
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
    return ((lfsr & 32'h7FFFFFFF) % (2 * amp + 1)) - amp;
  endfunction

  task automatic fill(int amp, int n);
    for (int i = 0; i < n; i++) vec[i] = rnd(amp);
  endtask

  // sends nsamp samples, last one closes; gap idle cycles between samples;
  // junk=1 drives stray samples during the busy window
  task automatic run_vec(input int nsamp, input int gap, input bit junk, input string tag);
    int k;
    bit exp_abn;
    bit rdy_ok;
    exp_abn = model_abn(nsamp > 38 ? 38 : nsamp);
    for (int s = 0; s < nsamp; s++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 16'(vec[s]);
      in_last  = (s == nsamp - 1);
      for (int g = 0; g < gap && s != nsamp - 1; g++) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = junk;
    in_last  = junk;
    in_data  = 16'h7FFF;
    k = 0;
    rdy_ok = 1'b1;
    while (k < 400) begin
      @(negedge clk);
      k++;
      if (out_valid) break;
      if (in_ready) rdy_ok = 1'b0;
      in_data = 16'(rnd(30000));
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    chk(rdy_ok, {"R8 ready low while busy ", tag}, int'(rdy_ok), 1);
    chk(k == 161, {"R7 latency ", tag}, k, 161);
    chk(out_abnormal == exp_abn, {"R6 decision ", tag}, int'(out_abnormal), int'(exp_abn));
    chk(in_ready == 1'b1, {"R8 ready at decision ", tag}, int'(in_ready), 1);
    @(negedge clk);
    chk(!out_valid && out_abnormal == exp_abn, {"R7 pulse and hold ", tag},
        int'({out_valid, out_abnormal}), int'(exp_abn));
  endtask

  task automatic t_reset;
    #1;
    chk(in_ready && !out_valid && !out_abnormal, "R1 reset state",
        int'({in_ready, out_valid, out_abnormal}), 4);
  endtask

  task automatic t_zero;
    for (int i = 0; i < 38; i++) vec[i] = 0;
    run_vec(38, 0, 1'b0, "R4 zero vector");
  endtask

  task automatic t_extremes;
    for (int i = 0; i < 38; i++) vec[i] = 32767;
    run_vec(38, 0, 1'b0, "R5 all max");
    for (int i = 0; i < 38; i++) vec[i] = -32768;
    run_vec(38, 0, 1'b0, "R5 all min");
    for (int i = 0; i < 38; i++) vec[i] = (i % 2 == 0) ? 20000 : -20000;
    run_vec(38, 0, 1'b0, "R5 alternating");
  endtask

  task automatic t_random;
    int amp [6] = '{300, 1500, 4000, 8000, 16000, 32000};
    int nabn = 0;
    for (int r = 0; r < 12; r++) begin
      fill(amp[r % 6], 38);
      if (model_abn(38)) nabn++;
      run_vec(38, 0, 1'b0, "R4 R6 mixed vector");
    end
    $display("info: %0d of 12 mixed vectors expected abnormal", nabn);
  endtask

  task automatic t_gaps;
    fill(6000, 38);
    run_vec(38, 2, 1'b0, "R2 gapped stream");
  endtask

  task automatic t_short_long;
    fill(9000, 38);
    for (int i = 10; i < 38; i++) vec[i] = 0;
    fill(9000, 10);
    run_vec(10, 0, 1'b0, "R3 short vector");
    fill(9000, 38);
    for (int i = 38; i < 45; i++) vec[i] = (i % 2 == 0) ? 32767 : -32768;
    run_vec(45, 0, 1'b0, "R3 overlong vector");
  endtask

  task automatic t_busy;
    fill(12000, 38);
    run_vec(38, 0, 1'b1, "R8 stray input while busy");
    fill(5000, 38);
    run_vec(38, 0, 1'b0, "R8 vector after stray input");
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_zero();
    t_extremes();
    t_random();
    t_gaps();
    t_short_long();
    t_busy();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule